// File: doc/BRIEF.md
# CAN Controller Interrupt Identifier Arbiter

This block gathers every interrupt source of a CAN controller with 32 message objects and presents a single identifier, plus a request line to the CPU. There are two kinds of source.

The first is a status source. A pulse raises it when a frame transfer completes successfully or when an error is seen on the bus. Reading the status register lowers it.

The second is one pending flag per message object. An object's flag can only be raised by an event that arrives while that object's interrupt enable is high. Only a clear strobe aimed at that object lowers it again.

Software reads the identifier to learn which source to service first. The status source always outranks the objects. Among the objects, the lowest number present wins, whatever order the events came in.

The identifier is registered. It follows a change of any pending flag by one clock. The request line combines that identifier with a global enable.

Top module: `can_irq_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released with no events, all pending flags are clear, `irq_id_o` is 0x0000 and `irq_o` is 0.
- R2: A message object's pending flag (object n on bit n-1 of the object buses) is set only when its set pulse and its enable bit are both high in the same cycle. A set pulse with the enable low leaves the identifier unchanged.
- R3: A status event pulse sets the status pending flag.
- R4: While the status flag is pending, `irq_id_o` reads 0x8000, whatever objects are also pending.
- R5: A status read strobe clears the status pending flag. The identifier then falls back to the object ranking.
- R6: With only message objects pending, `irq_id_o` equals the number (1 to 32) of the lowest-numbered pending object.
- R7: An object's pending flag stays set until its own clear strobe. A clear strobe affects no other object's flag.
- R8: When a set and a clear hit the same flag in the same cycle, the flag ends up set. This holds for an object set with its clear strobe, and for a status event with a status read.
- R9: With nothing pending, `irq_id_o` is 0x0000.
- R10: `irq_o` is high exactly when `glb_ie_i` is high and `irq_id_o` is non-zero.
- R11: An event sampled at clock edge k changes a pending flag at edge k, and `irq_id_o` shows the new value after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| obj_set_i | input | 32 | Per-object interrupt event pulses |
| obj_ie_i | input | 32 | Per-object interrupt enable bits |
| obj_clr_i | input | 32 | Per-object pending clear strobes from software |
| stat_evt_i | input | 1 | Status event pulse (transfer done or bus error) |
| stat_rd_i | input | 1 | Status register read strobe |
| glb_ie_i | input | 1 | Global interrupt enable |
| irq_id_o | output | 16 | Registered interrupt identifier |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench sets the status source on top of pending objects and expects 0x8000. A design that ranked the status source as an ordinary object would instead show an object number.

It sets objects in reverse numeric order and clears the winner, checking that the next-lowest number comes through. An arrival-ordered design would report the first object to arrive.

Set and clear strobes are driven together, on an object and on the status source. A design where the clear wins would drop the event, and the identifier would fall to the next source or to zero.

The bench also gates a set pulse with a low enable, checks that the identifier lags an event by exactly two edges, and runs a random mix against a reference model.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    // Width of the identifier register seen by software.
    localparam int unsigned ID_W = 16;

    // Code reported while the status source is pending.
    localparam logic [ID_W-1:0] STATUS_ID = 16'h8000;

    // Code reported when no source is pending.
    localparam logic [ID_W-1:0] IDLE_ID = '0;

endpackage

// File: rtl/can_irq_pend.sv
// Pending flag store: one flag per message object plus the status flag.
// A set always wins over a coincident clear.
module can_irq_pend #(
    parameter int unsigned NUM_OBJ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OBJ-1:0] obj_set_i,
    input  logic [NUM_OBJ-1:0] obj_ie_i,
    input  logic [NUM_OBJ-1:0] obj_clr_i,
    input  logic               stat_evt_i,
    input  logic               stat_rd_i,
    output logic [NUM_OBJ-1:0] obj_pend_o,
    output logic               stat_pend_o
);

    typedef struct packed {
        logic [NUM_OBJ-1:0] obj;
        logic               stat;
    } pend_t;

    pend_t pend_d, pend_q;
    logic [NUM_OBJ-1:0] obj_hit;

    // Only enabled objects may record an event.
    assign obj_hit = obj_set_i & obj_ie_i;

    always_comb begin
        pend_d = pend_q;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (obj_hit[i]) begin
                pend_d.obj[i] = 1'b1;
            end else if (obj_clr_i[i]) begin
                pend_d.obj[i] = 1'b0;
            end
        end
        if (stat_evt_i) begin
            pend_d.stat = 1'b1;
        end else if (stat_rd_i) begin
            pend_d.stat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign obj_pend_o  = pend_q.obj;
    assign stat_pend_o = pend_q.stat;

endmodule

// File: rtl/can_irq_prio.sv
// Fixed-priority selection: the status source first, then the
// lowest-numbered pending object (object n lives on bit n-1).
module can_irq_prio #(
    parameter int unsigned NUM_OBJ = 32
) (
    input  logic [NUM_OBJ-1:0]              obj_pend_i,
    input  logic                            stat_pend_i,
    output logic [can_irq_pkg::ID_W-1:0]    id_o
);
    import can_irq_pkg::*;

    logic [ID_W-1:0] obj_id;

    always_comb begin
        obj_id = IDLE_ID;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (obj_pend_i[i]) begin
                obj_id = ID_W'(i + 1);
            end
        end
    end

    assign id_o = stat_pend_i ? STATUS_ID : obj_id;

endmodule

// File: rtl/can_irq_arbiter.sv
module can_irq_arbiter #(
    parameter int unsigned NUM_OBJ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OBJ-1:0] obj_set_i,
    input  logic [NUM_OBJ-1:0] obj_ie_i,
    input  logic [NUM_OBJ-1:0] obj_clr_i,
    input  logic               stat_evt_i,
    input  logic               stat_rd_i,
    input  logic               glb_ie_i,
    output logic [15:0]        irq_id_o,
    output logic               irq_o
);
    import can_irq_pkg::*;

    typedef struct packed {
        logic [ID_W-1:0] id;
    } id_reg_t;

    logic [NUM_OBJ-1:0] obj_pend_q;
    logic               stat_pend_q;
    logic [ID_W-1:0]    id_sel;
    id_reg_t            idr_d, idr_q;

    can_irq_pend #(.NUM_OBJ(NUM_OBJ)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .obj_set_i   (obj_set_i),
        .obj_ie_i    (obj_ie_i),
        .obj_clr_i   (obj_clr_i),
        .stat_evt_i  (stat_evt_i),
        .stat_rd_i   (stat_rd_i),
        .obj_pend_o  (obj_pend_q),
        .stat_pend_o (stat_pend_q)
    );

    can_irq_prio #(.NUM_OBJ(NUM_OBJ)) u_prio (
        .obj_pend_i  (obj_pend_q),
        .stat_pend_i (stat_pend_q),
        .id_o        (id_sel)
    );

    always_comb begin
        idr_d    = idr_q;
        idr_d.id = id_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idr_q <= '0;
        end else begin
            idr_q <= idr_d;
        end
    end

    assign irq_id_o = idr_q.id;
    assign irq_o    = glb_ie_i && (idr_q.id != IDLE_ID);

endmodule

// File: rtl/can_irq_arbiter_chk.sv
module can_irq_arbiter_chk #(
    parameter int unsigned NUM_OBJ = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OBJ-1:0] obj_set_i,
    input logic [NUM_OBJ-1:0] obj_ie_i,
    input logic [NUM_OBJ-1:0] obj_clr_i,
    input logic               stat_evt_i,
    input logic               stat_rd_i,
    input logic               glb_ie_i,
    input logic [15:0]        irq_id_o,
    input logic               irq_o,
    input logic [NUM_OBJ-1:0] obj_pend_q,
    input logic               stat_pend_q
);

    a_r3_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        stat_evt_i |=> stat_pend_q);

    a_r4_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pend_q |=> (irq_id_o == 16'h8000));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !stat_evt_i) |=> !stat_pend_q);

    a_r2_gated_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((obj_pend_q & ~$past(obj_pend_q) & ~$past(obj_set_i & obj_ie_i)) == '0));

    a_r7_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((obj_pend_q & $past(obj_pend_q & ~obj_clr_i)) == $past(obj_pend_q & ~obj_clr_i)));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_pend_q && obj_pend_q == '0) |=> (irq_id_o == 16'h0000));

    a_r10_request_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_ie_i || irq_id_o == 16'h0000) |-> !irq_o);

endmodule

bind can_irq_arbiter can_irq_arbiter_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .obj_set_i   (obj_set_i),
    .obj_ie_i    (obj_ie_i),
    .obj_clr_i   (obj_clr_i),
    .stat_evt_i  (stat_evt_i),
    .stat_rd_i   (stat_rd_i),
    .glb_ie_i    (glb_ie_i),
    .irq_id_o    (irq_id_o),
    .irq_o       (irq_o),
    .obj_pend_q  (obj_pend_q),
    .stat_pend_q (stat_pend_q)
);

// File: tb/can_irq_arbiter_tb.sv
module can_irq_arbiter_tb;

    localparam int unsigned NOBJ = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NOBJ-1:0] obj_set = '0, obj_ie = '0, obj_clr = '0;
    logic            stat_evt = 1'b0, stat_rd = 1'b0, glb_ie = 1'b0;
    logic [15:0]     irq_id;
    logic            irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    can_irq_arbiter #(.NUM_OBJ(NOBJ)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .obj_set_i  (obj_set),
        .obj_ie_i   (obj_ie),
        .obj_clr_i  (obj_clr),
        .stat_evt_i (stat_evt),
        .stat_rd_i  (stat_rd),
        .glb_ie_i   (glb_ie),
        .irq_id_o   (irq_id),
        .irq_o      (irq)
    );

    typedef struct packed {
        logic [31:0] set;
        logic [31:0] ie;
        logic [31:0] clr;
        logic        evt;
        logic        rd;
        logic        gie;
        logic [15:0] exp_id;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0110, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b1, 16'd5,     1'b1}, // R6
        '{32'h0000_0004, 32'h0000_0000, 32'h0, 1'b0, 1'b0, 1'b1, 16'd5,     1'b1}, // R2
        '{32'h8000_0002, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b1, 16'd2,     1'b1}, // R6
        '{32'h0,         32'hFFFF_FFFF, 32'h2, 1'b0, 1'b0, 1'b1, 16'd5,     1'b1}, // R7
        '{32'h0,         32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b1, 16'h8000,  1'b1}, // R3 R4
        '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b1, 16'h8000,  1'b1}, // R4
        '{32'h0,         32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 1'b1, 16'd1,     1'b1}, // R5
        '{32'h0,         32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, 1'b1, 16'h8000,  1'b1}, // R8
        '{32'h0,         32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 1'b0, 16'd1,     1'b0}, // R5 R10
        '{32'h0000_0001, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1, 16'd1,     1'b1}, // R8
        '{32'h0,         32'hFFFF_FFFF, 32'h0000_0111, 1'b0, 1'b0, 1'b1, 16'd32, 1'b1}, // R7
        '{32'h0000_0040, 32'h0000_0040, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 16'd7, 1'b1}, // R7
        '{32'h0000_0008, 32'h0000_0040, 32'h0, 1'b0, 1'b0, 1'b1, 16'd7,     1'b1}, // R2
        '{32'h0,         32'h0000_0040, 32'h0000_0040, 1'b0, 1'b0, 1'b1, 16'd0, 1'b0}  // R9
    };

    task automatic check(input string req, input logic [15:0] act_id, input logic [15:0] exp_id,
                         input logic act_irq, input logic exp_irq);
        checks++;
        if (act_id !== exp_id || act_irq !== exp_irq) begin
            fails++;
            $display("FAIL %s: id=%h irq=%b expected id=%h irq=%b", req, act_id, act_irq, exp_id, exp_irq);
        end
    endtask

    task automatic idle_inputs();
        obj_set = '0; obj_clr = '0; stat_evt = 1'b0; stat_rd = 1'b0;
    endtask

    function automatic logic [15:0] ref_id(input logic [31:0] p, input logic s);
        logic [15:0] r;
        r = 16'h0;
        if (s) return 16'h8000;
        for (int i = 31; i >= 0; i--) if (p[i]) r = 16'(i + 1);
        return r;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: id=%h irq=%b expected run to complete", irq_id, irq);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] mp;
        logic        ms;
        logic        mg;
        // R1: state during and after reset
        glb_ie = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", irq_id, 16'h0, irq, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 after reset", irq_id, 16'h0, irq, 1'b0);

        // R11: identifier lags the event by two edges
        obj_set = 32'h0000_0200; obj_ie = '1;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check("R11 one edge", irq_id, 16'h0, irq, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R11 two edges", irq_id, 16'd10, irq, 1'b1);
        obj_clr = 32'h0000_0200;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        @(negedge clk);
        check("R9 cleared", irq_id, 16'h0, irq, 1'b0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            obj_set = VECS[v].set; obj_ie = VECS[v].ie; obj_clr = VECS[v].clr;
            stat_evt = VECS[v].evt; stat_rd = VECS[v].rd; glb_ie = VECS[v].gie;
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            @(posedge clk);
            @(negedge clk);
            check($sformatf("vector %0d R2-R10 group", v), irq_id, VECS[v].exp_id, irq, VECS[v].exp_irq);
        end

        // R1: reset with sources pending
        obj_set = 32'h0000_0003; obj_ie = '1; stat_evt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        @(negedge clk);
        check("R4 before reset", irq_id, 16'h8000, irq, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", irq_id, 16'h0, irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1 flags cleared", irq_id, 16'h0, irq, 1'b0);

        // Random mix against a reference model (R6 R7 R8 R4 R5 R10)
        mp = '0; ms = 1'b0;
        for (int n = 0; n < 300; n++) begin
            obj_set  = $urandom() & $urandom();
            obj_ie   = $urandom() | $urandom();
            obj_clr  = $urandom() & $urandom() & $urandom();
            stat_evt = ($urandom_range(0, 7) == 0);
            stat_rd  = ($urandom_range(0, 3) == 0);
            mg       = ($urandom_range(0, 5) != 0);
            glb_ie   = mg;
            mp = (mp & ~obj_clr) | (obj_set & obj_ie);
            ms = (ms & ~stat_rd) | stat_evt;
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            @(posedge clk);
            @(negedge clk);
            check("R6 random model", irq_id, ref_id(mp, ms), irq, mg && (ref_id(mp, ms) != 16'h0));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule